// File: doc/BRIEF.md
# Bus Address/Data Watchpoint Comparator

This block observes the bus cycles of one processor and raises a single-clock match flag when a cycle meets a configured condition. The flag feeds a trigger sequencer. Each cycle presents a 23-bit address, 16 bits of data, a write flag, a word-size flag and a valid strobe.

A static configuration selects one of three address modes. Exact mode compares the address and can also compare data. Inside mode matches when the address falls within an inclusive window. Outside mode matches when the address falls outside that window. The data compare uses a per-bit mask. Optional qualifiers can require a given access direction, a given access size, or both.

The match is registered. It appears in the clock after the qualifying cycle and stays high for exactly one clock.

Top module: `watchpoint_cmp`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `matchOut` is 0.
- R2: A cycle with `busValid` low never produces a match.
- R3: With `cfgEnable` low, `matchOut` stays 0 whatever the bus does.
- R4: With `cfgMode` = 2'b00 (exact), a match requires all 23 bits of `busAddr` to equal `cfgAddrLo`.
- R5: In exact mode with `cfgDataEn` = 1, a match also requires `busData` to equal `cfgData` on every bit whose `cfgDataMask` bit is 1. Bits whose mask bit is 0 are ignored. With `cfgDataEn` = 0, data is ignored.
- R6: With `cfgMode` = 2'b01 (inside), a match requires `cfgAddrLo` ≤ `busAddr` ≤ `cfgAddrHi`, with both bounds included. Data is ignored in this mode.
- R7: With `cfgMode` = 2'b10 (outside), a match requires `busAddr` < `cfgAddrLo` or `busAddr` > `cfgAddrHi`. Data is ignored in this mode.
- R8: With `cfgMode` = 2'b11 (reserved), there is never a match.
- R9: With `cfgDirEn` = 1, a match requires `busWrite` (1 = write, 0 = read) to equal `cfgDirWrite`. With `cfgDirEn` = 0, direction is ignored.
- R10: With `cfgSizeEn` = 1, a match requires `busWord` (1 = 16-bit word, 0 = byte) to equal `cfgSizeWord`. With `cfgSizeEn` = 0, size is ignored.
- R11: `matchOut` rises in the clock after a qualifying valid cycle and lasts one clock for each such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus cycle valid strobe |
| busAddr | input | 23 | Bus address |
| busData | input | 16 | Bus data |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = word access, 0 = byte access |
| cfgEnable | input | 1 | Comparator enable |
| cfgMode | input | 2 | 00 exact, 01 inside, 10 outside, 11 reserved |
| cfgAddrLo | input | 23 | Reference address / low bound |
| cfgAddrHi | input | 23 | High bound |
| cfgData | input | 16 | Reference data |
| cfgDataMask | input | 16 | 1 = bit takes part in data compare |
| cfgDataEn | input | 1 | Enable data compare in exact mode |
| cfgDirEn | input | 1 | Enable direction qualifier |
| cfgDirWrite | input | 1 | Required direction |
| cfgSizeEn | input | 1 | Enable size qualifier |
| cfgSizeWord | input | 1 | Required size |
| matchOut | output | 1 | Registered one-clock match flag |

## Verification
The bench walks addresses that sit exactly on, just inside and just outside both window bounds, in every mode. Addresses that differ only in the top bit are included. A design with an off-by-one bound would drop or add a match at `cfgAddrLo` or `cfgAddrHi`, and one that truncates the address would match a distant alias. Every mask pattern is tried against data that differs from the reference in a single bit, which exposes an inverted or ignored mask. Range modes are given mismatching data, and the reserved mode, the disable and an invalid strobe are all tried on otherwise matching cycles. Back-to-back and isolated hits expose a flag that stretches or comes out a cycle late.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT   = 2'b00,
    MODE_INSIDE  = 2'b01,
    MODE_OUTSIDE = 2'b10,
    MODE_RSVD    = 2'b11
  } wp_mode_e;

  // Strobes from the control half to the compare datapath
  typedef struct packed {
    logic armed;       // enabled and a valid bus cycle
    logic selExact;
    logic selInside;
    logic selOutside;
    logic useData;     // data compare active (exact mode only)
  } wp_strobe_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] cfgAddrLo,
  input  logic [ADDR_W-1:0] cfgAddrHi,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] cfgDataMask,
  input  logic              cfgDirEn,
  input  logic              cfgDirWrite,
  input  logic              cfgSizeEn,
  input  logic              cfgSizeWord,
  output logic              rawHit
);

  logic              addrEq, geLo, leHi;
  logic              inWin, outWin, exactHit;
  logic [DATA_W-1:0] bitMiss;
  logic              dataOk, dirOk, sizeOk, qualOk, winHit;

  // Full-width address comparisons against both bounds
  assign addrEq = (busAddr == cfgAddrLo);
  assign geLo   = (busAddr >= cfgAddrLo);
  assign leHi   = (busAddr <= cfgAddrHi);

  assign inWin  = geLo && leHi;
  assign outWin = (busAddr < cfgAddrLo) || (busAddr > cfgAddrHi);

  // Per-bit masked data compare
  for (genvar i = 0; i < DATA_W; i++) begin : g_dbit
    assign bitMiss[i] = cfgDataMask[i] & (busData[i] ^ cfgData[i]);
  end
  assign dataOk = ~|bitMiss;

  // Access qualifiers
  assign dirOk  = !cfgDirEn  || (busWrite == cfgDirWrite);
  assign sizeOk = !cfgSizeEn || (busWord  == cfgSizeWord);
  assign qualOk = dirOk && sizeOk;

  assign exactHit = addrEq && (!strobe.useData || dataOk);

  always_comb begin
    winHit = 1'b0;
    if (strobe.selExact)   winHit = exactHit;
    if (strobe.selInside)  winHit = inWin;
    if (strobe.selOutside) winHit = outWin;
  end

  assign rawHit = strobe.armed && qualOk && winHit;

  // The two window decisions are built independently and can never both hold
  p_window_split_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(inWin && outWin));

  // Equality with the reference implies the low-bound comparator agrees
  p_exact_on_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrEq |-> geLo);

  // At most one mode select is ever active
  p_one_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selExact, strobe.selInside, strobe.selOutside}));

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       cfgEnable,
  input  logic [1:0] cfgMode,
  input  logic       cfgDataEn,
  input  logic       rawHit,
  output wp_strobe_t strobe,
  output logic       matchOut
);

  wp_mode_e modeSel;
  logic     matchQ;

  assign modeSel = wp_mode_e'(cfgMode);

  always_comb begin
    strobe            = '0;
    strobe.armed      = cfgEnable && busValid;
    unique case (modeSel)
      MODE_EXACT:   strobe.selExact   = 1'b1;
      MODE_INSIDE:  strobe.selInside  = 1'b1;
      MODE_OUTSIDE: strobe.selOutside = 1'b1;
      default:      ;
    endcase
    strobe.useData = cfgDataEn && (modeSel == MODE_EXACT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= rawHit;
  end

  assign matchOut = matchQ;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !matchOut);

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !matchOut);

  p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b11) |=> !matchOut);

  p_pulse_per_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    rawHit |=> matchOut);

endmodule

// File: rtl/watchpoint_cmp.sv
module watchpoint_cmp
  import wp_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgAddrLo,
  input  logic [ADDR_W-1:0] cfgAddrHi,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] cfgDataMask,
  input  logic              cfgDataEn,
  input  logic              cfgDirEn,
  input  logic              cfgDirWrite,
  input  logic              cfgSizeEn,
  input  logic              cfgSizeWord,
  output logic              matchOut
);

  wp_strobe_t strobe;
  logic       rawHit;

  wp_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .cfgEnable (cfgEnable),
    .cfgMode   (cfgMode),
    .cfgDataEn (cfgDataEn),
    .rawHit    (rawHit),
    .strobe    (strobe),
    .matchOut  (matchOut)
  );

  wp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busAddr     (busAddr),
    .busData     (busData),
    .busWrite    (busWrite),
    .busWord     (busWord),
    .cfgAddrLo   (cfgAddrLo),
    .cfgAddrHi   (cfgAddrHi),
    .cfgData     (cfgData),
    .cfgDataMask (cfgDataMask),
    .cfgDirEn    (cfgDirEn),
    .cfgDirWrite (cfgDirWrite),
    .cfgSizeEn   (cfgSizeEn),
    .cfgSizeWord (cfgSizeWord),
    .rawHit      (rawHit)
  );

  p_dir_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDirEn && (busWrite != cfgDirWrite)) |=> !matchOut);

  p_size_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSizeEn && (busWord != cfgSizeWord)) |=> !matchOut);

endmodule

// File: tb/watchpoint_cmp_tb.sv
`timescale 1ns/1ps
module watchpoint_cmp_tb;

  localparam int AW = 23;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busValid, busWrite, busWord;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;
  logic          cfgEnable, cfgDataEn, cfgDirEn, cfgDirWrite, cfgSizeEn, cfgSizeWord;
  logic [1:0]    cfgMode;
  logic [AW-1:0] cfgAddrLo, cfgAddrHi;
  logic [DW-1:0] cfgData, cfgDataMask;
  logic          matchOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  watchpoint_cmp u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .busWrite(busWrite), .busWord(busWord),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgAddrLo(cfgAddrLo),
    .cfgAddrHi(cfgAddrHi), .cfgData(cfgData), .cfgDataMask(cfgDataMask),
    .cfgDataEn(cfgDataEn), .cfgDirEn(cfgDirEn), .cfgDirWrite(cfgDirWrite),
    .cfgSizeEn(cfgSizeEn), .cfgSizeWord(cfgSizeWord), .matchOut(matchOut)
  );

  // Expected match from the requirements, using current stimulus
  function automatic bit expMatch();
    bit win;
    bit q;
    case (cfgMode)
      2'b00: win = (busAddr == cfgAddrLo) &&
                   (!cfgDataEn || (((busData ^ cfgData) & cfgDataMask) == '0));
      2'b01: win = (busAddr >= cfgAddrLo) && (busAddr <= cfgAddrHi);
      2'b10: win = (busAddr < cfgAddrLo) || (busAddr > cfgAddrHi);
      default: win = 1'b0;
    endcase
    q = (!cfgDirEn || busWrite == cfgDirWrite) && (!cfgSizeEn || busWord == cfgSizeWord);
    return busValid && cfgEnable && win && q;
  endfunction

  task automatic check(input bit exp, input string tag);
    nChecks++;
    if (matchOut !== exp) begin
      nFails++;
      $display("FAIL %s: matchOut=%0b expected=%0b (mode=%0b addr=%h data=%h wr=%0b wd=%0b)",
               tag, matchOut, exp, cfgMode, busAddr, busData, busWrite, busWord);
    end
  endtask

  // Drive a cycle at the falling edge, sample one register later
  task automatic busCycle(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic w, input logic wd, input string tag);
    bit e;
    @(negedge clk);
    busValid = v; busAddr = a; busData = d; busWrite = w; busWord = wd;
    e = expMatch();
    @(posedge clk);
    #1;
    check(e, tag);
  endtask

  function automatic logic [AW-1:0] probe(input int k);
    case (k)
      0: return '0;
      1: return cfgAddrLo - 1;
      2: return cfgAddrLo;
      3: return cfgAddrLo + 1;
      4: return cfgAddrHi - 1;
      5: return cfgAddrHi;
      6: return cfgAddrHi + 1;
      7: return cfgAddrLo ^ 23'h400000;   // top-bit alias
      default: return '1;
    endcase
  endfunction

  function automatic string modeTag(input int m);
    case (m)
      0: return "R4 R9 R10";
      1: return "R6 R9 R10";
      2: return "R7 R9 R10";
      default: return "R8";
    endcase
  endfunction

  initial begin
    rstN = 1'b0;
    busValid = 0; busAddr = '0; busData = '0; busWrite = 0; busWord = 0;
    cfgEnable = 1; cfgMode = 2'b00; cfgAddrLo = 23'h001200; cfgAddrHi = 23'h0012FF;
    cfgData = 16'hA5C3; cfgDataMask = 16'hFFFF; cfgDataEn = 0;
    cfgDirEn = 0; cfgDirWrite = 1; cfgSizeEn = 0; cfgSizeWord = 0;

    // R1: held in reset with a matching cycle present
    @(negedge clk);
    busValid = 1; busAddr = cfgAddrLo;
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1; busValid = 0;
    @(posedge clk); #1 check(1'b0, "R1 after release");

    // Sweep modes x address probes x qualifier settings x direction x size
    for (int m = 0; m < 4; m++) begin
      cfgMode = m[1:0];
      for (int qc = 0; qc < 4; qc++) begin
        cfgDirEn = qc[0]; cfgSizeEn = qc[1];
        for (int k = 0; k < 9; k++)
          for (int w = 0; w < 2; w++)
            for (int wd = 0; wd < 2; wd++)
              busCycle(1'b1, probe(k), 16'h0F0F, w[0], wd[0], modeTag(m));
      end
    end
    cfgDirEn = 0; cfgSizeEn = 0;

    // R5: masked data compare, single-bit differences against several masks
    cfgMode = 2'b00; cfgDataEn = 1;
    for (int mi = 0; mi < 5; mi++) begin
      case (mi)
        0: cfgDataMask = 16'hFFFF;
        1: cfgDataMask = 16'h00FF;
        2: cfgDataMask = 16'hFF00;
        3: cfgDataMask = 16'h0000;
        default: cfgDataMask = 16'h8001;
      endcase
      busCycle(1'b1, cfgAddrLo, cfgData, 1'b0, 1'b1, "R5 equal data");
      for (int b = 0; b < DW; b++)
        busCycle(1'b1, cfgAddrLo, cfgData ^ (16'h1 << b), 1'b0, 1'b1, "R5 one bit off");
    end
    cfgDataMask = 16'hFFFF;
    cfgDataEn = 0;
    busCycle(1'b1, cfgAddrLo, ~cfgData, 1'b0, 1'b0, "R5 compare off");
    // R6 / R7: data ignored in range modes even when enabled
    cfgDataEn = 1;
    cfgMode = 2'b01;
    busCycle(1'b1, cfgAddrLo + 5, ~cfgData, 1'b1, 1'b0, "R6 data ignored");
    cfgMode = 2'b10;
    busCycle(1'b1, cfgAddrHi + 5, ~cfgData, 1'b1, 1'b0, "R7 data ignored");
    cfgDataEn = 0;

    // R2: invalid strobe on matching cycles in every active mode
    for (int m = 0; m < 3; m++) begin
      cfgMode = m[1:0];
      busCycle(1'b0, (m == 2) ? 23'h7FFFFF : cfgAddrLo, cfgData, 1'b0, 1'b0, "R2 invalid");
    end

    // R3: disabled comparator
    cfgEnable = 0; cfgMode = 2'b01;
    for (int k = 1; k < 7; k++)
      busCycle(1'b1, probe(k), cfgData, 1'b1, 1'b1, "R3 disabled");
    cfgEnable = 1;

    // R11: back-to-back hits then an isolated hit
    cfgMode = 2'b01;
    busCycle(1'b1, cfgAddrLo, 16'h0, 1'b0, 1'b0, "R11 first hit");
    busCycle(1'b1, cfgAddrHi, 16'h0, 1'b0, 1'b0, "R11 second hit");
    busCycle(1'b0, cfgAddrHi, 16'h0, 1'b0, 1'b0, "R11 drop after hit");
    busCycle(1'b1, cfgAddrHi + 1, 16'h0, 1'b0, 1'b0, "R11 miss");
    busCycle(1'b1, cfgAddrLo + 7, 16'h0, 1'b0, 1'b0, "R11 isolated hit");
    busCycle(1'b0, '0, 16'h0, 1'b0, 1'b0, "R11 single clock");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule